// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Register Bank

This block is the digital front end of an eight-channel, 13-bit parallel-input converter. A host writes a 13-bit code over a simple parallel bus with a 3-bit channel address and active-low select and write strobes. Each channel holds its code in two stages. An input register takes bus data. An output register drives the channel's code output and is loaded from the input register. Because of the two stages, the host can stage new codes in several channels and then move them to the outputs together.

Output registers are loaded by four active-low load strobes, one for each channel pair. An active-low clear acts without the clock and forces every register in both stages to midscale. Every bus and strobe input passes through a two-flop synchronizer. The level-transparent behaviour is modelled by updating a register on each clock for which its enable condition holds. A monitor finite-state machine (FSM) enforces the rule that a load held low across a write must stay low for a number of cycles after the write ends. A one-cycle pulse reports every change of an output code.

The monitor FSM has three states. MON_IDLE leaves on start-write (write seen) to MON_WRITE. MON_WRITE loops on write-continue, which re-arms the pair mask. It leaves on write-end-unarmed to MON_IDLE, on early-release (an armed pair's load already high) to MON_IDLE with the error set, or on write-end-armed to MON_HOLD. MON_HOLD leaves on rewrite to MON_WRITE, on hold-met (count reached) to MON_IDLE, or on early-release to MON_IDLE with the error set. Otherwise it takes hold-count and stays.

Top module: `octal_dac_regbank`

## Requirements
- R1: After `rst_n` is released, every channel's `code_out` field reads 0x1000, `upd_pulse` is 0 and `hold_err` is 0.
- R2: A write happens when both `cs_n` and `wr_n` are low. It loads `data` into the input register of the channel given by `addr`, where 0..7 maps to channels A..H (0..7). Inputs sampled at clock edge k reach the registers at edge k+2, after the two-flop synchronizer.
- R3: No input register changes while `cs_n` or `wr_n` is high.
- R4: While `ld_n[p]` is low, the output registers of channels 2p and 2p+1 follow their input registers. Here `ld_n[0]`=A/B, `ld_n[1]`=C/D, `ld_n[2]`=E/F and `ld_n[3]`=G/H. The other pairs are not affected.
- R5: An output register holds its value while its pair's load strobe is high.
- R6: A write to a channel whose pair load is low passes the bus data to that channel's output in the same cycle that the input register takes it.
- R7: While `clr_n` is low, every input and output register holds 0x1000 without waiting for a clock. This overrides `cs_n`, `wr_n` and `ld_n`, and the value stays after `clr_n` rises.
- R8: `upd_pulse` is high for the one cycle after a clock edge at which some output register took a different value. Loading an equal value gives no pulse.
- R9: Suppose `ld_n[p]` is low on the last cycle of a write. If it then rises fewer than HOLD_CYC (default 4) cycles after the write ends, `hold_err` is set. Rising at HOLD_CYC cycles or later is not flagged.
- R10: `hold_err` stays set until `rst_n`. `clr_n` does not clear it.
- R11: Channel k's output code is on `code_out[13k+12:13k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Asynchronous active-low clear to midscale |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write |
| addr | input | 3 | Channel address, 0=A .. 7=H |
| data | input | 13 | Code data bus |
| ld_n | input | 4 | Active-low load strobes, one per channel pair |
| code_out | output | 104 | Output-register codes, channel k at bits 13k+12:13k |
| upd_pulse | output | 1 | One-cycle pulse after any output code change |
| hold_err | output | 1 | Sticky flag for a load released too soon after a write |

## Verification
The bench checks the boundaries of the load-hold window. A release exactly HOLD_CYC cycles after the write must not flag, and one cycle earlier must flag. A monitor with an off-by-one count would fail one side of this pair. Flow-through is checked while the write is still held. A design that loaded outputs only from the registered input value would show the old code at that point. The bench applies clear between clock edges and drives a write and a load during it. A clear that was synchronous, or that could be overridden, would leave non-midscale codes. The bench also loads an equal value and expects no pulse, which catches a pulse tied to the load strobe rather than to a change in the code.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

    // Default geometry of the bank
    localparam int DEF_PAIRS    = 4;
    localparam int DEF_DW       = 13;
    localparam int DEF_HOLD_CYC = 4;

    // Post-write load hold monitor states
    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_WRITE = 2'd1,
        MON_HOLD  = 2'd2
    } mon_state_e;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
    parameter int            DW       = 13,
    parameter logic [DW-1:0] CLR_CODE = '0
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          wr_hit,
    input  logic          ld_act,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] in_q,
    output logic [DW-1:0] out_q,
    output logic          chg
);

    logic [DW-1:0] in_nx;
    logic [DW-1:0] out_nx;

    // Input stage follows the bus while addressed; output stage follows
    // the next input value so a held load passes write data straight on.
    always_comb begin
        in_nx  = wr_hit ? bus : in_q;
        out_nx = ld_act ? in_nx : out_q;
        chg    = (out_nx != out_q);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            in_q  <= CLR_CODE;
            out_q <= CLR_CODE;
        end else begin
            in_q  <= in_nx;
            out_q <= out_nx;
        end
    end

endmodule

// File: rtl/dac_hold_mon.sv
module dac_hold_mon
    import dac_regbank_pkg::*;
#(
    parameter int NP       = 4,
    parameter int HOLD_CYC = 4,
    localparam int CW      = $clog2(HOLD_CYC + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_act,
    input  logic [NP-1:0] ld_act,
    output logic          err
);

    localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYC);

    mon_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [NP-1:0] arm_q, arm_d;
    logic          err_q, err_d;
    logic          early;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
            cnt_q   <= '0;
            arm_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            arm_q   <= arm_d;
            err_q   <= err_d;
        end
    end

    // Any armed pair whose load has already been released
    assign early = |(arm_q & ~ld_act);

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        arm_d   = arm_q;
        err_d   = err_q;
        unique case (state_q)
            MON_IDLE: begin
                if (wr_act) begin
                    state_d = MON_WRITE;
                    arm_d   = ld_act;
                end
            end
            MON_WRITE: begin
                if (wr_act) begin
                    arm_d = ld_act;
                end else if (arm_q == '0) begin
                    state_d = MON_IDLE;
                end else if (early && (HOLD_CYC > 0)) begin
                    err_d   = 1'b1;
                    state_d = MON_IDLE;
                    arm_d   = '0;
                end else begin
                    cnt_d   = CW'(1);
                    state_d = MON_HOLD;
                end
            end
            MON_HOLD: begin
                if (wr_act) begin
                    state_d = MON_WRITE;
                    arm_d   = ld_act;
                end else if (cnt_q >= HOLD_LIM) begin
                    state_d = MON_IDLE;
                    arm_d   = '0;
                end else if (early) begin
                    err_d   = 1'b1;
                    state_d = MON_IDLE;
                    arm_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = MON_IDLE;
                arm_d   = '0;
            end
        endcase
    end

    assign err = err_q;

endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NUM_PAIRS = DEF_PAIRS,
    parameter int DW        = DEF_DW,
    parameter int HOLD_CYC  = DEF_HOLD_CYC,
    localparam int NUM_CH   = 2 * NUM_PAIRS,
    localparam int AW       = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_n,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        data,
    input  logic [NUM_PAIRS-1:0] ld_n,
    output logic [NUM_CH*DW-1:0] code_out,
    output logic                 upd_pulse,
    output logic                 hold_err
);

    localparam logic [DW-1:0] CLR_CODE = DW'(1) << (DW - 1);
    localparam int            CTL_W    = 2 + NUM_PAIRS;
    localparam int            BUS_W    = AW + DW;

    // Synchronized bus and strobes
    logic [CTL_W-1:0]     ctl_s;
    logic [BUS_W-1:0]     bus_s;
    logic                 wr_act;
    logic [AW-1:0]        wr_addr;
    logic [DW-1:0]        wr_data;
    logic [NUM_PAIRS-1:0] ld_act;
    logic                 arst_n;

    // Per-channel state
    logic [NUM_CH*DW-1:0] in_flat;
    logic [NUM_CH*DW-1:0] out_flat;
    logic [NUM_CH-1:0]    chg_vec;
    logic                 upd_q;

    dac_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, wr_n, ld_n}),
        .q     (ctl_s)
    );

    dac_sync #(.W(BUS_W), .RST_VAL({BUS_W{1'b0}})) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, data}),
        .q     (bus_s)
    );

    assign wr_act  = ~ctl_s[CTL_W-1] & ~ctl_s[CTL_W-2];
    assign ld_act  = ~ctl_s[NUM_PAIRS-1:0];
    assign wr_addr = bus_s[BUS_W-1:DW];
    assign wr_data = bus_s[DW-1:0];

    // Clear acts on both register stages without the clock
    assign arst_n = rst_n & clr_n;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        logic wr_hit;
        assign wr_hit = wr_act && (wr_addr == AW'(k));

        dac_chan #(.DW(DW), .CLR_CODE(CLR_CODE)) u_chan (
            .clk    (clk),
            .arst_n (arst_n),
            .wr_hit (wr_hit),
            .ld_act (ld_act[k/2]),
            .bus    (wr_data),
            .in_q   (in_flat[k*DW +: DW]),
            .out_q  (out_flat[k*DW +: DW]),
            .chg    (chg_vec[k])
        );
    end

    // Change pulse, registered alongside the output stage
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= |chg_vec;
        end
    end

    dac_hold_mon #(.NP(NUM_PAIRS), .HOLD_CYC(HOLD_CYC)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_act (wr_act),
        .ld_act (ld_act),
        .err    (hold_err)
    );

    assign code_out  = out_flat;
    assign upd_pulse = upd_q;

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
    parameter int NCH = 8,
    parameter int NP  = 4,
    parameter int DW  = 13,
    parameter int AW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_n,
    input logic           wr_act,
    input logic [AW-1:0]  wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [NP-1:0]  ld_act,
    input logic [NCH*DW-1:0] in_flat,
    input logic [NCH*DW-1:0] out_flat,
    input logic           upd_pulse,
    input logic           hold_err
);

    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    assert_inputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !wr_act |=> $stable(in_flat));

    assert_clear_midscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (out_flat == {NCH{MID}} && in_flat == {NCH{MID}}));

    assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        upd_pulse |-> (out_flat != $past(out_flat)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_err |=> hold_err);

    for (genvar p = 0; p < NP; p++) begin : g_pair
        assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            !ld_act[p] |=> $stable(out_flat[2*p*DW +: 2*DW]));
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assert_flow_through_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            (wr_act && wr_addr == AW'(k) && ld_act[k/2])
            |=> (out_flat[k*DW +: DW] == $past(wr_data)));
    end

endmodule

bind octal_dac_regbank dac_regbank_chk #(
    .NCH(NUM_CH), .NP(NUM_PAIRS), .DW(DW), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .wr_act    (wr_act),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ld_act    (ld_act),
    .in_flat   (in_flat),
    .out_flat  (out_flat),
    .upd_pulse (upd_pulse),
    .hold_err  (hold_err)
);

// File: tb/octal_dac_regbank_tb.sv
module octal_dac_regbank_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NP   = 4;
    localparam int NCH  = 8;
    localparam int DW   = 13;
    localparam int HOLD = 4;
    localparam logic [DW-1:0] MID = 13'h1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic cs_n = 1'b1;
    logic wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic [NP-1:0] ld_n = '1;
    logic [NCH*DW-1:0] code_out;
    logic upd_pulse;
    logic hold_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] in_m  [NCH];
    logic [DW-1:0] out_m [NCH];

    always #4 clk = ~clk;

    octal_dac_regbank #(.NUM_PAIRS(NP), .DW(DW), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .data(data), .ld_n(ld_n), .code_out(code_out),
        .upd_pulse(upd_pulse), .hold_err(hold_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] field(input int k);
        return code_out[k*DW +: DW];
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < NCH; k++)
            chk(field(k) == out_m[k], req, field(k), out_m[k]);
    endtask

    // mode 0: real write, 1: cs_n held high, 2: wr_n held high
    task automatic do_write(input int a, input logic [DW-1:0] d, input int mode);
        addr = 3'(a); data = d;
        cs_n = (mode == 1); wr_n = (mode == 2);
        tick(2);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(4);
        if (mode == 0) in_m[a] = d;
    endtask

    task automatic do_load(input logic [NP-1:0] mask);
        ld_n = ~mask;
        tick(2);
        ld_n = '1;
        tick(4);
        for (int k = 0; k < NCH; k++)
            if (mask[k/2]) out_m[k] = in_m[k];
    endtask

    initial begin
        #1600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin in_m[k] = MID; out_m[k] = MID; end
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state, R11 field layout
        check_all("R1 R11 reset code");
        chk(upd_pulse == 1'b0, "R1 upd_pulse", upd_pulse, 0);
        chk(hold_err == 1'b0, "R1 hold_err", hold_err, 0);

        // R2 directed: every address then a global load
        for (int k = 0; k < NCH; k++) do_write(k, DW'(13'h0111 * (k + 1)), 0);
        check_all("R5 outputs held before load");
        do_load(4'b0101);
        check_all("R4 pairs AB EF loaded only");
        do_load(4'b1010);
        check_all("R2 R4 all channels");

        // R3 ignored writes, observed through a load
        do_write(5, 13'h1ABC, 1);
        do_write(6, 13'h0CDE, 2);
        do_load(4'b1111);
        check_all("R3 ignored writes");

        // R8 pulse timing: change then equal value
        do_write(0, 13'h0F0F, 0);
        ld_n = 4'b1110;
        tick(3);
        chk(upd_pulse == 1'b1, "R8 pulse on change", upd_pulse, 1);
        tick(1);
        chk(upd_pulse == 1'b0, "R8 pulse one cycle", upd_pulse, 0);
        ld_n = '1;
        tick(4);
        out_m[0] = in_m[0]; out_m[1] = in_m[1];
        begin
            bit seen = 0;
            ld_n = 4'b1110;
            for (int i = 0; i < 6; i++) begin tick(1); if (upd_pulse) seen = 1; end
            ld_n = '1;
            tick(4);
            chk(seen == 0, "R8 no pulse equal value", seen, 0);
        end

        // R6 flow-through and R9 exact-boundary release
        ld_n = 4'b1101;
        tick(4);
        out_m[2] = in_m[2]; out_m[3] = in_m[3];
        addr = 3'd2; data = 13'h15A5; cs_n = 1'b0; wr_n = 1'b0;
        tick(4);
        chk(field(2) == 13'h15A5, "R6 flow-through during write", field(2), 13'h15A5);
        chk(field(3) == out_m[3], "R6 partner unchanged", field(3), out_m[3]);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(HOLD);
        ld_n = '1;
        tick(6);
        in_m[2] = 13'h15A5; out_m[2] = 13'h15A5;
        chk(hold_err == 1'b0, "R9 release at limit allowed", hold_err, 0);
        check_all("R6 after release");

        // Random traffic, fixed seed
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 80; i++) begin
            int op = int'($urandom_range(0, 3));
            if (op == 3) do_load(NP'($urandom_range(1, 15)));
            else do_write(int'($urandom_range(0, 7)), DW'($urandom), op);
            check_all("R2 R3 R4 random");
        end
        chk(hold_err == 1'b0, "R9 no false error", hold_err, 0);

        // R9 early release by one cycle
        ld_n = 4'b0111;
        addr = 3'd7; data = 13'h0777; cs_n = 1'b0; wr_n = 1'b0;
        tick(3);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(HOLD - 1);
        ld_n = '1;
        tick(6);
        in_m[7] = 13'h0777; out_m[6] = in_m[6]; out_m[7] = 13'h0777;
        chk(hold_err == 1'b1, "R9 early release flagged", hold_err, 1);
        check_all("R6 GH outputs");

        // R7 asynchronous clear between edges, overriding strobes
        #1;
        clr_n = 1'b0;
        #1;
        for (int k = 0; k < NCH; k++)
            chk(field(k) == MID, "R7 async clear", field(k), MID);
        addr = 3'd1; data = 13'h0001; cs_n = 1'b0; wr_n = 1'b0;
        tick(4);
        cs_n = 1'b1; wr_n = 1'b1;
        ld_n = '0;
        tick(4);
        ld_n = '1;
        tick(4);
        for (int k = 0; k < NCH; k++) begin
            chk(field(k) == MID, "R7 clear overrides", field(k), MID);
            in_m[k] = MID; out_m[k] = MID;
        end
        clr_n = 1'b1;
        tick(4);
        do_load(4'b1111);
        check_all("R7 input stage cleared");
        chk(hold_err == 1'b1, "R10 sticky through clear", hold_err, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule